// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache that sits between a processor load/store port and a slower next-level memory port. Each byte address is cut into three fields. The low bits select a byte and a word inside a line. The next bits select one of `LINES` lines. The remaining high bits form the tag, which is stored with the line. An access hits when the selected line is valid and its stored tag equals the address tag. On a miss, the processor is held on `cpu_stall`. The whole line is then fetched one word per memory beat, and the held access completes from the freshly installed line.

The write policy is fixed at build time. In write-back mode (`WRITE_BACK=1`), stores only touch the line and mark it dirty. A dirty line is copied out in full before a different line is fetched into its slot. In write-through mode, every accepted store is also posted into a small FIFO that drains to memory in the background. A second parameter, `WT_ALLOCATE`, decides whether a store miss fetches the line first or bypasses the cache.

The processor holds its request fields stable while `cpu_stall` is high. Read data is valid in the cycle where `cpu_req` is high and `cpu_stall` is low. The memory side holds `mem_req` and its fields until the cycle where `mem_ready` is high. For a read, `mem_rdata` is taken in that same cycle.

Top module: `dm_cache`

## Requirements
- R1: The line index is (byte address / (4·LINE_WORDS)) mod LINES. With the defaults (8 lines of 4 words), byte address bits 3:2 select the word, bits 6:4 the line, and bits 31:7 the tag. Two addresses 128 bytes apart therefore compete for one line, while addresses in different lines do not disturb each other.
- R2: After reset every line is invalid, `mem_req` is low, and `cpu_stall` is low while no request is present.
- R3: A read whose line is valid with a matching tag returns the stored word with `cpu_stall` low in the request's first cycle.
- R4: A read miss stalls the processor and fetches words 0 to LINE_WORDS−1 of the line in increasing order, one word per beat. The line becomes valid only after the last word. With a memory that raises `mem_ready` in the cycle after each request appears, and no queued stores, the stall lasts 2 + 2·LINE_WORDS cycles (10 with the defaults).
- R5: In write-through mode, a store hit updates the line and is posted to memory. It does not stall while the buffer has room.
- R6: The write-through buffer holds WBUF_DEPTH (4) stores and writes them to memory in arrival order, so the later of two stores to one word wins. A store arriving while the buffer is full stalls until an entry drains.
- R7: In write-through mode, a store miss with `WT_ALLOCATE=1` fetches the line, so a later read of that word hits. With `WT_ALLOCATE=0`, the store is only posted, the line stays unallocated, and the store does not stall while the buffer has room.
- R8: A line fetch is not issued until the write buffer is empty, so a read after a bypassing store returns the stored value.
- R9: In write-back mode, a store hit updates only the line, never stalls, and issues no memory write.
- R10: In write-back mode, replacing a dirty line first writes all of its words to memory, then fetches the new line. Under the R4 memory timing, the stall lasts 2 + 4·LINE_WORDS cycles (18). The installed line is clean, so replacing it later writes nothing.
- R11: In write-back mode, a store miss fetches the line and then merges the store into it, leaving memory untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Hold the current access |
| cpu_rdata | output | 32 | Load data, valid when stall is low |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Beat completes this cycle |
| mem_rdata | input | 32 | Read beat data, taken with `mem_ready` |

## Verification
The assertions assume that the memory side completes a beat only while `mem_req` is high. The bench memory model raises `mem_ready` only on a cycle after a request has been seen, and drops it for one cycle after every beat. The design's checks also rely on the processor holding its address stable through a stall. The bench drives each access from a task that keeps every request field unchanged until `cpu_stall` falls, and only issues word-aligned addresses inside the modelled 1 KB memory.

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W      = 32,
  parameter int LINES       = 8,
  parameter int LINE_WORDS  = 4,
  parameter int WRITE_BACK  = 1,
  parameter int WT_ALLOCATE = 1,
  parameter int WBUF_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_stall,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int PTR_W  = $clog2(WBUF_DEPTH);
  localparam int CNT_W  = $clog2(WBUF_DEPTH + 1);
  localparam bit WB     = (WRITE_BACK != 0);
  localparam bit ALLOC  = (WT_ALLOCATE != 0);
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_MISS, S_EVICT, S_FILL} state_t;
  state_t state;

  logic [TAG_W-1:0] tags [LINES];
  logic [31:0]      data [LINES*LINE_WORDS];
  logic [LINES-1:0] valid, dirty;
  logic [WSEL_W-1:0] beat;
  logic [TAG_W-1:0] m_tag;
  logic [IDX_W-1:0] m_idx;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_word;
  logic hit, needs_fill, accept, line_wr, push, pop, unused_bits;

  assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx       = cpu_addr[OFF_W +: IDX_W];
  assign a_word      = cpu_addr[2 +: WSEL_W];
  assign unused_bits = ^cpu_addr[1:0];
  assign hit         = valid[a_idx] && (tags[a_idx] == a_tag);
  assign needs_fill  = !hit && (!cpu_we || WB || ALLOC);
  assign cpu_rdata   = data[{a_idx, a_word}];

  // write buffer
  logic [ADDR_W-1:0] fb_addr [WBUF_DEPTH];
  logic [31:0]       fb_data [WBUF_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fb_cnt;
  logic fb_empty, fb_full;

  assign fb_empty = (fb_cnt == '0);
  assign fb_full  = (fb_cnt == CNT_W'(WBUF_DEPTH));

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(WBUF_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (!cpu_req)                    cpu_stall = 1'b0;
    else if (state != S_IDLE)        cpu_stall = 1'b1;
    else if (needs_fill)             cpu_stall = 1'b1;
    else if (cpu_we && !WB && fb_full) cpu_stall = 1'b1;
    else                             cpu_stall = 1'b0;
  end

  assign accept  = cpu_req && !cpu_stall;
  assign line_wr = accept && cpu_we && hit;
  assign push    = accept && cpu_we && !WB;
  assign pop     = !fb_empty && mem_ready && (state == S_IDLE || state == S_MISS);

  always_comb begin
    mem_req   = !fb_empty;
    mem_we    = 1'b1;
    mem_addr  = fb_addr[rd_ptr];
    mem_wdata = fb_data[rd_ptr];
    case (state)
      S_EVICT: begin
        mem_req   = 1'b1;
        mem_addr  = {tags[m_idx], m_idx, beat, 2'b00};
        mem_wdata = data[{m_idx, beat}];
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_we   = 1'b0;
        mem_addr = {m_tag, m_idx, beat, 2'b00};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      valid <= '0;
      dirty <= '0;
      beat  <= '0;
      m_tag <= '0;
      m_idx <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cpu_req && needs_fill) begin
            state <= S_MISS;
            m_tag <= a_tag;
            m_idx <= a_idx;
          end else if (line_wr && WB) begin
            dirty[a_idx] <= 1'b1;
          end
        end
        S_MISS: begin
          beat <= '0;
          if (WB && valid[m_idx] && dirty[m_idx]) begin
            state <= S_EVICT;
          end else if (fb_empty) begin
            state        <= S_FILL;
            valid[m_idx] <= 1'b0;
          end
        end
        S_EVICT: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST) begin
            state        <= S_FILL;
            beat         <= '0;
            valid[m_idx] <= 1'b0;
          end
        end
        S_FILL: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST) begin
            state        <= S_IDLE;
            valid[m_idx] <= 1'b1;
            dirty[m_idx] <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && mem_ready) begin
      data[{m_idx, beat}] <= mem_rdata;
      if (beat == LAST) tags[m_idx] <= m_tag;
    end else if (line_wr) begin
      data[{a_idx, a_word}] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      fb_addr[wr_ptr] <= cpu_addr;
      fb_data[wr_ptr] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fb_cnt <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      fb_cnt <= fb_cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fb_cnt <= CNT_W'(WBUF_DEPTH)); // R6
  AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> fb_empty); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ready && beat != LAST) |=> (state == S_FILL && beat == $past(beat) + 1'b1)); // R4
  AST_VALID_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ready && beat == LAST) |=> (valid[$past(m_idx)] && !dirty[$past(m_idx)])); // R10
  AST_INVALID_WHILE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL) |-> !valid[m_idx]); // R4
  AST_WB_WRITES_ON_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (WB && mem_req && mem_we) |-> (state == S_EVICT)); // R9
endmodule

// File: tb/tb_dm_cache.sv
`timescale 1ns/1ps
module tb_dm_cache;
  localparam int N = 3;
  localparam int WORDS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] req, we, stall, mreq, mwe, mrdy;
  logic [N-1:0][31:0] addr, wd, rd, maddr, mwd, mrd;
  logic [31:0] mem [N][WORDS];
  logic [N-1:0][WORDS-1:0] wrt;
  int wcnt [N];
  int rcnt [N];
  logic [7:0] rlog [N][16];

  logic [31:0] gold [N][WORDS];
  int stag [N][8];
  bit sval [N][8];
  bit sdirty [N][8];
  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] seed(input int k, input int i);
    return {8'(k + 1), 8'h5A, 16'(i * 37 + 3)};
  endfunction

  function automatic logic [31:0] memv(input int k, input int i);
    return wrt[k][i] ? mem[k][i] : seed(k, i);
  endfunction

  // cfg 0: write-back, cfg 1: write-through allocate, cfg 2: write-through write-around
  for (genvar k = 0; k < N; k++) begin : g_cfg
    dm_cache #(.WRITE_BACK(k == 0 ? 1 : 0), .WT_ALLOCATE(k == 1 ? 1 : 0)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[k]), .cpu_we(we[k]), .cpu_addr(addr[k]), .cpu_wdata(wd[k]),
      .cpu_stall(stall[k]), .cpu_rdata(rd[k]),
      .mem_req(mreq[k]), .mem_we(mwe[k]), .mem_addr(maddr[k]), .mem_wdata(mwd[k]),
      .mem_ready(mrdy[k]), .mem_rdata(mrd[k]));
    assign mrd[k] = wrt[k][maddr[k][9:2]] ? mem[k][maddr[k][9:2]] : seed(k, int'(maddr[k][9:2]));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (!rst_n) begin
        mrdy[k] <= 1'b0;
        wrt[k]  <= '0;
        wcnt[k] <= 0;
        rcnt[k] <= 0;
      end else begin
        mrdy[k] <= mreq[k] && !mrdy[k];
        if (mrdy[k] && mreq[k]) begin
          if (mwe[k]) begin
            mem[k][maddr[k][9:2]] <= mwd[k];
            wrt[k][maddr[k][9:2]] <= 1'b1;
            wcnt[k] <= wcnt[k] + 1;
          end else begin
            rlog[k][rcnt[k][3:0]] <= maddr[k][9:2];
            rcnt[k] <= rcnt[k] + 1;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic op(input int k, input bit w, input int a, input logic [31:0] d,
                    output int cyc, output logic [31:0] v);
    @(negedge clk);
    req[k] = 1'b1; we[k] = w; addr[k] = 32'(a); wd[k] = d;
    cyc = 0;
    #1;
    while (stall[k] && cyc < 2000) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    if (cyc >= 2000) chk(1'b0, "R4 stall never released", cyc, 0);
    v = rd[k];
    @(posedge clk);
    #1;
    req[k] = 1'b0;
  endtask

  task automatic do_rd(input int k, input int a, output int cyc, output logic [31:0] v);
    int ln = (a >> 4) & 7;
    int tg = a >> 7;
    int wi = (a >> 2) & 255;
    bit hit = sval[k][ln] && stag[k][ln] == tg;
    bit dty = sval[k][ln] && sdirty[k][ln];
    op(k, 1'b0, a, 32'h0, cyc, v);
    chk(v === gold[k][wi], "R3 load data", v, gold[k][wi]);
    if (hit) chk(cyc == 0, "R3 hit without stall", cyc, 0);
    else if (k == 0) chk(cyc == (dty ? 18 : 10), dty ? "R10 dirty miss penalty" : "R4 clean miss penalty", cyc, dty ? 18 : 10);
    else chk(cyc >= 10, "R4 miss stalls for a refill", cyc, 10);
    if (!hit) begin
      sval[k][ln] = 1'b1; stag[k][ln] = tg; sdirty[k][ln] = 1'b0;
    end
  endtask

  task automatic do_wr(input int k, input int a, input logic [31:0] d, output int cyc);
    int ln = (a >> 4) & 7;
    int tg = a >> 7;
    int wi = (a >> 2) & 255;
    bit hit = sval[k][ln] && stag[k][ln] == tg;
    bit dty = sval[k][ln] && sdirty[k][ln];
    logic [31:0] v;
    op(k, 1'b1, a, d, cyc, v);
    if (k == 0) chk(cyc == (hit ? 0 : (dty ? 18 : 10)), "R11 write-back store stall", cyc, hit ? 0 : (dty ? 18 : 10));
    if (!hit && k != 2) begin
      sval[k][ln] = 1'b1; stag[k][ln] = tg; sdirty[k][ln] = 1'b0;
    end
    if (k == 0) sdirty[k][ln] = 1'b1;
    gold[k][wi] = d;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, w0, r0, tot;
    logic [31:0] v, old, s;
    req = '0; we = '0; addr = '0; wd = '0;
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < WORDS; i++) gold[k][i] = seed(k, i);
      for (int l = 0; l < 8; l++) begin sval[k][l] = 0; sdirty[k][l] = 0; stag[k][l] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < N; k++) begin
      chk(stall[k] == 1'b0, "R2 no stall when idle after reset", stall[k], 0);
      chk(mreq[k] == 1'b0, "R2 no memory request after reset", mreq[k], 0);
      do_rd(k, 'h40, c, v);
      chk(c == 10, "R2 first access misses (lines invalid)", c, 10);
      do_rd(k, 'h44, c, v);
      chk(c == 0, "R1 other word of same line hits", c, 0);
      do_rd(k, 'hC0, c, v);
      chk(c != 0, "R1 address 128 bytes away conflicts", c, 1);
      do_rd(k, 'h50, c, v);
      chk(c != 0, "R1 next line is a separate miss", c, 1);
      do_rd(k, 'hC4, c, v);
      chk(c == 0, "R1 neighbour fill leaves line intact", c, 0);
    end

    // R4 fill order
    r0 = rcnt[0];
    do_rd(0, 'h1C8, c, v);
    chk(rcnt[0] - r0 == 4, "R4 one read beat per word", rcnt[0] - r0, 4);
    for (int j = 0; j < 4; j++)
      chk(rlog[0][(r0 + j) & 15] == 8'(('h1C0 >> 2) + j), "R4 words fetched in increasing order",
          rlog[0][(r0 + j) & 15], ('h1C0 >> 2) + j);

    // R5 / R6 write-through
    do_rd(1, 'h100, c, v);
    settle();
    w0 = wcnt[1];
    do_wr(1, 'h104, 32'hFACE0001, c);
    chk(c == 0, "R5 store hit does not stall", c, 0);
    settle();
    chk(memv(1, 'h104 >> 2) == 32'hFACE0001, "R5 store reaches memory", memv(1, 'h104 >> 2), 32'hFACE0001);
    chk(wcnt[1] - w0 == 1, "R5 one memory write", wcnt[1] - w0, 1);
    do_rd(1, 'h104, c, v);
    w0 = wcnt[1]; tot = 0;
    for (int j = 0; j < 8; j++) begin
      do_wr(1, 'h100 + 4 * (j % 4), 32'hC0DE0000 + 32'(j), c);
      tot += c;
    end
    chk(tot > 0, "R6 full buffer stalls a store", tot, 1);
    settle();
    chk(wcnt[1] - w0 == 8, "R6 every store drained", wcnt[1] - w0, 8);
    for (int j = 0; j < 4; j++)
      chk(memv(1, ('h100 >> 2) + j) == 32'hC0DE0004 + 32'(j), "R6 drained in arrival order",
          memv(1, ('h100 >> 2) + j), 32'hC0DE0004 + 32'(j));

    // R9 write-back hits
    do_rd(0, 'h100, c, v);
    settle();
    w0 = wcnt[0]; tot = 0;
    for (int j = 0; j < 8; j++) begin
      do_wr(0, 'h100 + 4 * (j % 4), 32'hB0B00000 + 32'(j), c);
      tot += c;
    end
    chk(tot == 0, "R9 store hits never stall", tot, 0);
    settle();
    chk(wcnt[0] == w0, "R9 store hits issue no memory write", wcnt[0] - w0, 0);

    // R7 allocate vs write-around
    settle();
    do_wr(1, 'h200, 32'hA11C0001, c);
    do_rd(1, 'h200, c, v);
    chk(c == 0, "R7 allocating store miss leaves line resident", c, 0);
    settle();
    do_wr(2, 'h200, 32'hA20D0002, c);
    chk(c == 0, "R7 write-around miss does not stall", c, 0);
    settle();
    do_rd(2, 'h200, c, v);
    chk(c != 0, "R7 write-around leaves line unallocated", c, 1);
    chk(v == 32'hA20D0002, "R7 write-around data in memory", v, 32'hA20D0002);

    // R8 refill waits for drain
    settle();
    do_wr(2, 'h304, 32'hD8A10008, c);
    do_rd(2, 'h304, c, v);
    chk(v == 32'hD8A10008, "R8 refill sees queued store", v, 32'hD8A10008);
    chk(c >= 10, "R8 refill waited", c, 10);

    // R10 dirty eviction
    settle();
    w0 = wcnt[0];
    do_rd(0, 'h180, c, v);
    chk(c == 18, "R10 dirty replacement penalty", c, 18);
    chk(wcnt[0] - w0 == 4, "R10 whole line written back", wcnt[0] - w0, 4);
    for (int j = 0; j < 4; j++)
      chk(memv(0, ('h100 >> 2) + j) == gold[0][('h100 >> 2) + j], "R10 written-back contents",
          memv(0, ('h100 >> 2) + j), gold[0][('h100 >> 2) + j]);
    old = gold[0]['h184 >> 2];
    w0 = wcnt[0];
    do_wr(0, 'h184, 32'h0DD10009, c);
    settle();
    chk(memv(0, 'h184 >> 2) == old, "R9 store hit leaves memory unchanged", memv(0, 'h184 >> 2), old);
    do_rd(0, 'h380, c, v);
    chk(memv(0, 'h184 >> 2) == 32'h0DD10009, "R10 eviction carries stored word", memv(0, 'h184 >> 2), 32'h0DD10009);
    w0 = wcnt[0];
    do_rd(0, 'h180, c, v);
    chk(c == 10 && wcnt[0] == w0, "R10 refilled line is clean", wcnt[0] - w0, 0);

    // R11 write-back store miss
    old = gold[0]['h284 >> 2];
    do_wr(0, 'h284, 32'h5EED0011, c);
    chk(c == 10, "R11 store miss fetches line", c, 10);
    do_rd(0, 'h284, c, v);
    chk(c == 0 && v == 32'h5EED0011, "R11 store merged into fetched line", v, 32'h5EED0011);
    do_rd(0, 'h280, c, v);
    chk(c == 0, "R11 neighbour word came with the fetch", c, 0);
    chk(memv(0, 'h284 >> 2) == old, "R11 memory untouched by store miss", memv(0, 'h284 >> 2), old);

    // mixed sweep and full readback
    for (int k = 0; k < N; k++) begin
      s = 32'h1234567 + 32'(k);
      for (int n = 0; n < 500; n++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        if (((s >> 20) % 3) == 0) do_wr(k, int'((s >> 8) & 32'h3FC), s ^ 32'h9E3779B9, c);
        else do_rd(k, int'((s >> 8) & 32'h3FC), c, v);
      end
      for (int i = 0; i < WORDS; i++) do_rd(k, i * 4, c, v);
      settle();
      for (int i = 0; i < WORDS; i++) begin
        int ln = (i >> 2) & 7;
        bit held = (k == 0) && sval[k][ln] && sdirty[k][ln] && stag[k][ln] == (i >> 5);
        if (!held) chk(memv(k, i) == gold[k][i], k == 0 ? "R9 memory matches outside dirty lines" : "R5 memory mirrors stores",
                       memv(k, i), gold[k][i]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule